// File: doc/BRIEF.md
# Branch Outcome Check and Fetch Redirect

This block sits in the execute stage of a five-stage in-order pipeline. It owns the pipeline register that carries an instruction, its predicted-taken bit and its program counter from the operand-read stage into execute. Once a conditional branch sits in execute, the block decides whether the branch is really taken. It uses the ALU sign and zero flags for this. It then compares that outcome with the prediction that was made earlier.

When the two disagree, the block kills the two younger instructions by pulsing flush requests for the post-fetch and post-operand-read pipeline registers. It also loads the program counter with the correct path. That path is the ALU result when the branch is taken, or the branch address plus one when it is not. The operand-read stage may redirect fetch speculatively in the same cycle. In that case the block's own correction wins.

For every branch it sees, the block also sends out the instruction and its real outcome once, so that a predictor can learn from it. A stall holds the branch in execute without repeating any of these pulses. A misprediction found during a stall is remembered until the stage register loads again.

Top module: `bvr_unit`

## Requirements
- R1: The opcode is instruction bits [15:12]. Opcode 4'h8 branches on negative and opcode 4'h9 branches on zero. The real outcome is taken when the opcode is 4'h8 with the N flag set, or 4'h9 with the Z flag set, and not taken otherwise.
- R2: A branch in execute whose real outcome differs from its carried prediction bit asserts both `flush_fetch_o` and `flush_rr_o`, and the next instruction loaded into execute is a NOP (opcode 4'hD, all other fields zero). A correct prediction asserts neither flush.
- R3: On a misprediction whose real outcome is taken, `pc_load_o` is high and `pc_next_o` equals `alu_q_i`.
- R4: On a misprediction whose real outcome is not taken, `pc_load_o` is high and `pc_next_o` equals the branch's own address (`ex_pc_o`) plus one.
- R5: Every branch in execute raises `upd_valid_o` for one cycle. In that cycle `upd_insn_o` is the branch instruction and `upd_taken_o` is its real outcome, whether or not the prediction was correct.
- R6: When the stage register loads (stall low, no bubble), the execute outputs take the instruction, prediction bit and address from the operand-read inputs without change. With `ex_stall_i` high they hold. With `ex_bubble_i` high they load a NOP with zero prediction and zero address.
- R7: A non-branch instruction or a NOP in execute never asserts a flush or `upd_valid_o`. In that case `pc_load_o` follows only `rr_redir_valid_i`.
- R8: A branch held in execute by `ex_stall_i` raises its flush, redirect and update outputs only in its first cycle there.
- R9: When a misprediction and `rr_redir_valid_i` fall in the same cycle, `pc_next_o` is the correction from R3/R4. Without a misprediction, `rr_redir_valid_i` gives `pc_load_o` high with `pc_next_o` equal to `rr_redir_pc_i`.
- R10: A misprediction found while `ex_stall_i` is high is remembered. The first load after the stall ends puts a NOP into execute instead of the operand-read instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rr_insn_i | input | 16 | Instruction leaving operand read |
| rr_pred_i | input | 1 | Predicted-taken bit leaving operand read |
| rr_pc_i | input | 16 | Address of the instruction leaving operand read |
| ex_stall_i | input | 1 | Holds the execute stage register |
| ex_bubble_i | input | 1 | Loads a NOP into the execute stage register |
| alu_n_i | input | 1 | ALU negative flag |
| alu_z_i | input | 1 | ALU zero flag |
| alu_q_i | input | 16 | ALU result, the taken target of a branch |
| rr_redir_valid_i | input | 1 | Speculative redirect request from operand read |
| rr_redir_pc_i | input | 16 | Speculative redirect target |
| ex_insn_o | output | 16 | Instruction in execute |
| ex_pred_o | output | 1 | Prediction bit in execute |
| ex_pc_o | output | 16 | Address of the instruction in execute |
| flush_fetch_o | output | 1 | Bubble request for the post-fetch register |
| flush_rr_o | output | 1 | Bubble request for the post-operand-read register |
| pc_load_o | output | 1 | Load the program counter |
| pc_next_o | output | 16 | New program counter value |
| upd_valid_o | output | 1 | Predictor training strobe |
| upd_insn_o | output | 16 | Branch instruction for training |
| upd_taken_o | output | 1 | Real outcome for training |

## Verification
Two functions can land on the program-counter port in the same cycle: the correction from a mispredicted branch in execute, and the speculative redirect from operand read. The bench provokes both at once by putting a wrongly predicted branch into execute while it holds `rr_redir_valid_i` high with a different target. It then expects the correction address on `pc_next_o`. It repeats the case with a correctly predicted branch and expects the speculative target to pass through. A stalled misprediction is also checked, to see that the deferred squash does not re-pulse the flushes.

// File: rtl/bvr_pkg.sv
package bvr_pkg;

  // Width of the opcode field at the top of every instruction word.
  localparam int unsigned OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_BR_NEG = 4'h8,
    OPC_BR_ZERO = 4'h9,
    OPC_NOP    = 4'hD
  } opc_e;

  // True for any conditional branch opcode.
  function automatic logic opc_is_branch(input logic [OPC_W-1:0] opc);
    return (opc == OPC_BR_NEG) || (opc == OPC_BR_ZERO);
  endfunction

endpackage

// File: rtl/bvr_rst_sync.sv
module bvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  // Asserts at once, releases after STAGES rising edges.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bvr_stage_reg.sv
module bvr_stage_reg
  import bvr_pkg::*;
#(
  parameter int unsigned IW = 16,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          bubble,
  input  logic [IW-1:0] d_insn,
  input  logic          d_pred,
  input  logic [PW-1:0] d_pc,
  output logic [IW-1:0] q_insn,
  output logic          q_pred,
  output logic [PW-1:0] q_pc
);

  localparam int unsigned LOW_W = IW - OPC_W;
  localparam logic [IW-1:0] NOP_WORD = {OPC_NOP, {LOW_W{1'b0}}};

  logic [IW-1:0] insn_d;
  logic          pred_d;
  logic [PW-1:0] pc_d;

  // Next-state selection: bubble forces a NOP, otherwise pass through.
  always_comb begin
    if (bubble) begin
      insn_d = NOP_WORD;
      pred_d = 1'b0;
      pc_d   = '0;
    end else begin
      insn_d = d_insn;
      pred_d = d_pred;
      pc_d   = d_pc;
    end
  end

  // Register with an explicit load enable; holding equals stalling.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_insn <= NOP_WORD;
      q_pred <= 1'b0;
      q_pc   <= '0;
    end else if (load_en) begin
      q_insn <= insn_d;
      q_pred <= pred_d;
      q_pc   <= pc_d;
    end
  end

endmodule

// File: rtl/bvr_resolve.sv
module bvr_resolve
  import bvr_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic             pred,
  input  logic             flag_n,
  input  logic             flag_z,
  input  logic             already_done,
  output logic             eval,
  output logic             taken,
  output logic             mispredict
);

  logic is_br;
  logic cond_neg;
  logic cond_zero;

  always_comb begin
    is_br     = opc_is_branch(opc);
    cond_neg  = (opc == OPC_BR_NEG)  && flag_n;
    cond_zero = (opc == OPC_BR_ZERO) && flag_z;
    taken     = cond_neg || cond_zero;
    // Only the first cycle a branch spends in execute counts.
    eval       = is_br && !already_done;
    mispredict = eval && (taken != pred);
  end

endmodule

// File: rtl/bvr_redirect.sv
module bvr_redirect #(
  parameter int unsigned PW = 16
) (
  input  logic          mispredict,
  input  logic          taken,
  input  logic [PW-1:0] target,
  input  logic [PW-1:0] branch_pc,
  input  logic          spec_valid,
  input  logic [PW-1:0] spec_pc,
  output logic          pc_load,
  output logic [PW-1:0] pc_next
);

  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  logic [PW-1:0] fallthru;
  logic [PW-1:0] recover;

  always_comb begin
    fallthru = branch_pc + ONE;
    recover  = taken ? target : fallthru;
    pc_load  = mispredict || spec_valid;
    // Correction of the older instruction overrides the younger guess.
    if (mispredict) begin
      pc_next = recover;
    end else if (spec_valid) begin
      pc_next = spec_pc;
    end else begin
      pc_next = '0;
    end
  end

endmodule

// File: rtl/bvr_unit.sv
module bvr_unit
  import bvr_pkg::*;
#(
  parameter int unsigned IW = 16,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rr_insn_i,
  input  logic          rr_pred_i,
  input  logic [PW-1:0] rr_pc_i,
  input  logic          ex_stall_i,
  input  logic          ex_bubble_i,
  input  logic          alu_n_i,
  input  logic          alu_z_i,
  input  logic [PW-1:0] alu_q_i,
  input  logic          rr_redir_valid_i,
  input  logic [PW-1:0] rr_redir_pc_i,
  output logic [IW-1:0] ex_insn_o,
  output logic          ex_pred_o,
  output logic [PW-1:0] ex_pc_o,
  output logic          flush_fetch_o,
  output logic          flush_rr_o,
  output logic          pc_load_o,
  output logic [PW-1:0] pc_next_o,
  output logic          upd_valid_o,
  output logic [IW-1:0] upd_insn_o,
  output logic          upd_taken_o
);

  localparam int unsigned OPC_LSB = IW - OPC_W;

  logic rst_sync_n;
  logic load_en;
  logic stage_bubble;
  logic eval;
  logic taken;
  logic mispredict;
  logic resolved_q, resolved_d;
  logic squash_pend_q, squash_pend_d;

  bvr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign load_en      = !ex_stall_i;
  assign stage_bubble = ex_bubble_i || mispredict || squash_pend_q;

  bvr_stage_reg #(.IW(IW), .PW(PW)) u_stage (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (load_en),
    .bubble  (stage_bubble),
    .d_insn  (rr_insn_i),
    .d_pred  (rr_pred_i),
    .d_pc    (rr_pc_i),
    .q_insn  (ex_insn_o),
    .q_pred  (ex_pred_o),
    .q_pc    (ex_pc_o)
  );

  bvr_resolve u_resolve (
    .opc          (ex_insn_o[IW-1:OPC_LSB]),
    .pred         (ex_pred_o),
    .flag_n       (alu_n_i),
    .flag_z       (alu_z_i),
    .already_done (resolved_q),
    .eval         (eval),
    .taken        (taken),
    .mispredict   (mispredict)
  );

  bvr_redirect #(.PW(PW)) u_redirect (
    .mispredict (mispredict),
    .taken      (taken),
    .target     (alu_q_i),
    .branch_pc  (ex_pc_o),
    .spec_valid (rr_redir_valid_i),
    .spec_pc    (rr_redir_pc_i),
    .pc_load    (pc_load_o),
    .pc_next    (pc_next_o)
  );

  // Bookkeeping for a branch held in execute by a stall.
  always_comb begin
    resolved_d    = resolved_q;
    squash_pend_d = squash_pend_q;
    if (load_en) begin
      resolved_d    = 1'b0;
      squash_pend_d = 1'b0;
    end else begin
      if (eval) begin
        resolved_d = 1'b1;
      end
      if (mispredict) begin
        squash_pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      resolved_q    <= 1'b0;
      squash_pend_q <= 1'b0;
    end else begin
      resolved_q    <= resolved_d;
      squash_pend_q <= squash_pend_d;
    end
  end

  assign flush_fetch_o = mispredict;
  assign flush_rr_o    = mispredict;
  assign upd_valid_o   = eval;
  assign upd_insn_o    = ex_insn_o;
  assign upd_taken_o   = taken;

endmodule

// File: rtl/bvr_unit_chk.sv
module bvr_unit_chk
  import bvr_pkg::*;
#(
  parameter int unsigned IW = 16,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_sync_n,
  input  logic          squash_pend_q,
  input  logic [IW-1:0] rr_insn_i,
  input  logic          rr_pred_i,
  input  logic          ex_stall_i,
  input  logic          ex_bubble_i,
  input  logic          alu_n_i,
  input  logic          alu_z_i,
  input  logic [PW-1:0] alu_q_i,
  input  logic          rr_redir_valid_i,
  input  logic [PW-1:0] rr_redir_pc_i,
  input  logic [IW-1:0] ex_insn_o,
  input  logic          ex_pred_o,
  input  logic [PW-1:0] ex_pc_o,
  input  logic          flush_fetch_o,
  input  logic          flush_rr_o,
  input  logic          pc_load_o,
  input  logic [PW-1:0] pc_next_o,
  input  logic          upd_valid_o,
  input  logic [IW-1:0] upd_insn_o,
  input  logic          upd_taken_o
);

  localparam int unsigned OPC_LSB = IW - OPC_W;
  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  logic [OPC_W-1:0] ex_opc;
  logic             real_taken;
  assign ex_opc     = ex_insn_o[IW-1:OPC_LSB];
  assign real_taken = ((ex_opc == OPC_BR_NEG) && alu_n_i) || ((ex_opc == OPC_BR_ZERO) && alu_z_i);

  assert_outcome_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upd_valid_o |-> (upd_taken_o == real_taken));

  assert_flush_pair_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_fetch_o == flush_rr_o);

  assert_flush_on_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upd_valid_o |-> (flush_fetch_o == (upd_taken_o != ex_pred_o)));

  assert_taken_target_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flush_fetch_o && upd_taken_o) |-> (pc_load_o && pc_next_o == alu_q_i));

  assert_fallthru_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flush_fetch_o && !upd_taken_o) |-> (pc_load_o && pc_next_o == ex_pc_o + ONE));

  assert_update_insn_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upd_valid_o |-> (upd_insn_o == ex_insn_o));

  assert_carry_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ex_stall_i && !ex_bubble_i && !flush_rr_o && !squash_pend_q) |=>
      (ex_pred_o == $past(rr_pred_i) && ex_insn_o == $past(rr_insn_i)));

  assert_quiet_nonbranch_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !opc_is_branch(ex_opc) |-> (!flush_fetch_o && !upd_valid_o && pc_load_o == rr_redir_valid_i));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid_o || flush_fetch_o) |=> (!upd_valid_o && !flush_fetch_o));

  assert_spec_pass_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rr_redir_valid_i && !flush_fetch_o) |-> (pc_load_o && pc_next_o == rr_redir_pc_i));

  assert_deferred_squash_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (squash_pend_q && !ex_stall_i) |=> (ex_opc == OPC_NOP));

endmodule

bind bvr_unit bvr_unit_chk #(.IW(IW), .PW(PW)) u_chk (
  .clk              (clk),
  .rst_sync_n       (rst_sync_n),
  .squash_pend_q    (squash_pend_q),
  .rr_insn_i        (rr_insn_i),
  .rr_pred_i        (rr_pred_i),
  .ex_stall_i       (ex_stall_i),
  .ex_bubble_i      (ex_bubble_i),
  .alu_n_i          (alu_n_i),
  .alu_z_i          (alu_z_i),
  .alu_q_i          (alu_q_i),
  .rr_redir_valid_i (rr_redir_valid_i),
  .rr_redir_pc_i    (rr_redir_pc_i),
  .ex_insn_o        (ex_insn_o),
  .ex_pred_o        (ex_pred_o),
  .ex_pc_o          (ex_pc_o),
  .flush_fetch_o    (flush_fetch_o),
  .flush_rr_o       (flush_rr_o),
  .pc_load_o        (pc_load_o),
  .pc_next_o        (pc_next_o),
  .upd_valid_o      (upd_valid_o),
  .upd_insn_o       (upd_insn_o),
  .upd_taken_o      (upd_taken_o)
);

// File: tb/bvr_unit_tb.sv
`timescale 1ns/1ps
module bvr_unit_tb_top;

  localparam int IW = 16;
  localparam int PW = 16;
  localparam logic [15:0] INSN_ADD = 16'h1234;
  localparam logic [15:0] INSN_NOP = 16'hD000;

  logic          clk;
  logic          rst_n;
  logic [IW-1:0] rr_insn_i;
  logic          rr_pred_i;
  logic [PW-1:0] rr_pc_i;
  logic          ex_stall_i;
  logic          ex_bubble_i;
  logic          alu_n_i;
  logic          alu_z_i;
  logic [PW-1:0] alu_q_i;
  logic          rr_redir_valid_i;
  logic [PW-1:0] rr_redir_pc_i;
  logic [IW-1:0] ex_insn_o;
  logic          ex_pred_o;
  logic [PW-1:0] ex_pc_o;
  logic          flush_fetch_o;
  logic          flush_rr_o;
  logic          pc_load_o;
  logic [PW-1:0] pc_next_o;
  logic          upd_valid_o;
  logic [IW-1:0] upd_insn_o;
  logic          upd_taken_o;

  int checks;
  int failures;
  bit finished;

  bvr_unit #(.IW(IW), .PW(PW)) dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic quiet_inputs();
    ex_stall_i = 1'b0; ex_bubble_i = 1'b0;
    alu_n_i = 1'b0; alu_z_i = 1'b0; alu_q_i = '0;
    rr_redir_valid_i = 1'b0; rr_redir_pc_i = '0;
  endtask

  // Put an instruction into execute; returns just after the next falling edge.
  task automatic load_ex(input logic [15:0] insn, input logic pred, input logic [15:0] pc);
    quiet_inputs();
    rr_insn_i = insn; rr_pred_i = pred; rr_pc_i = pc;
    @(negedge clk);
    rr_insn_i = INSN_ADD; rr_pred_i = 1'b0; rr_pc_i = 16'h0999;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    quiet_inputs();
    rr_insn_i = INSN_ADD; rr_pred_i = 1'b1; rr_pc_i = 16'h0010;
    repeat (3) @(negedge clk);
    check(ex_insn_o == INSN_NOP, "R6 reset insn", ex_insn_o, INSN_NOP);
    check(!flush_fetch_o && !pc_load_o && !upd_valid_o, "R7 reset quiet",
          {flush_fetch_o, pc_load_o, upd_valid_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_carry();
    load_ex(16'h1ABC, 1'b1, 16'h003A);
    check(ex_insn_o == 16'h1ABC && ex_pred_o && ex_pc_o == 16'h003A, "R6 carry",
          {ex_insn_o, ex_pc_o}, {16'h1ABC, 16'h003A});
    ex_stall_i = 1'b1;
    @(negedge clk);
    check(ex_insn_o == 16'h1ABC && ex_pred_o, "R6 stall hold", ex_insn_o, 16'h1ABC);
    ex_stall_i = 1'b0; ex_bubble_i = 1'b1;
    @(negedge clk);
    check(ex_insn_o == INSN_NOP && !ex_pred_o && ex_pc_o == 0, "R6 bubble",
          {ex_insn_o, ex_pc_o}, {INSN_NOP, 16'h0});
    ex_bubble_i = 1'b0;
  endtask

  task automatic t_mispredict_taken();
    load_ex(16'h9014, 1'b0, 16'h0100);
    alu_z_i = 1'b1; alu_q_i = 16'h0140;
    #1;
    check(flush_fetch_o && flush_rr_o, "R2 flush on mismatch", {flush_fetch_o, flush_rr_o}, 3);
    check(upd_taken_o == 1'b1, "R1 zero-branch taken", upd_taken_o, 1);
    check(pc_load_o && pc_next_o == 16'h0140, "R3 taken target", pc_next_o, 16'h0140);
    check(upd_valid_o && upd_insn_o == 16'h9014, "R5 update insn", upd_insn_o, 16'h9014);
    @(negedge clk);
    check(ex_insn_o == INSN_NOP, "R2 younger squashed", ex_insn_o, INSN_NOP);
  endtask

  task automatic t_mispredict_not_taken();
    load_ex(16'h8022, 1'b1, 16'h0200);
    alu_n_i = 1'b0; alu_z_i = 1'b1; alu_q_i = 16'h0222;
    #1;
    check(upd_taken_o == 1'b0, "R1 neg-branch not taken on Z", upd_taken_o, 0);
    check(flush_rr_o, "R2 flush on mismatch", flush_rr_o, 1);
    check(pc_load_o && pc_next_o == 16'h0201, "R4 fall-through", pc_next_o, 16'h0201);
    @(negedge clk);
  endtask

  task automatic t_correct();
    load_ex(16'h8F05, 1'b1, 16'h0300);
    alu_n_i = 1'b1;
    #1;
    check(!flush_fetch_o && !pc_load_o, "R2 no flush when right", {flush_fetch_o, pc_load_o}, 0);
    check(upd_valid_o && upd_taken_o, "R5 update on correct", {upd_valid_o, upd_taken_o}, 3);
    @(negedge clk);
  endtask

  task automatic t_nonbranch();
    load_ex(INSN_ADD, 1'b1, 16'h0400);
    alu_n_i = 1'b1; alu_z_i = 1'b1;
    #1;
    check(!flush_fetch_o && !upd_valid_o && !pc_load_o, "R7 plain insn quiet",
          {flush_fetch_o, upd_valid_o, pc_load_o}, 0);
    rr_redir_valid_i = 1'b1; rr_redir_pc_i = 16'h0AAA;
    #1;
    check(pc_load_o && pc_next_o == 16'h0AAA, "R7 spec redirect only", pc_next_o, 16'h0AAA);
    @(negedge clk);
  endtask

  task automatic t_priority();
    load_ex(16'h8011, 1'b0, 16'h0500);
    alu_n_i = 1'b1; alu_q_i = 16'h0055;
    rr_redir_valid_i = 1'b1; rr_redir_pc_i = 16'h0077;
    #1;
    check(pc_load_o && pc_next_o == 16'h0055, "R9 correction wins", pc_next_o, 16'h0055);
    @(negedge clk);
    load_ex(16'h8011, 1'b1, 16'h0600);
    alu_n_i = 1'b1; alu_q_i = 16'h0055;
    rr_redir_valid_i = 1'b1; rr_redir_pc_i = 16'h0077;
    #1;
    check(pc_load_o && pc_next_o == 16'h0077, "R9 spec passes", pc_next_o, 16'h0077);
    @(negedge clk);
  endtask

  task automatic t_stall_pulse();
    load_ex(16'h9033, 1'b1, 16'h0700);
    alu_z_i = 1'b1; ex_stall_i = 1'b1;
    #1;
    check(upd_valid_o, "R8 first stalled cycle updates", upd_valid_o, 1);
    @(negedge clk);
    check(!upd_valid_o && ex_insn_o == 16'h9033, "R8 no repeat update", upd_valid_o, 0);
    ex_stall_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stall_squash();
    load_ex(16'h8044, 1'b0, 16'h0800);
    alu_n_i = 1'b1; alu_q_i = 16'h0860; ex_stall_i = 1'b1;
    #1;
    check(flush_fetch_o && pc_next_o == 16'h0860, "R10 stalled mispredict", pc_next_o, 16'h0860);
    @(negedge clk);
    check(!flush_fetch_o && !pc_load_o, "R8 no repeat flush", {flush_fetch_o, pc_load_o}, 0);
    ex_stall_i = 1'b0;
    @(negedge clk);
    check(ex_insn_o == INSN_NOP, "R10 deferred squash", ex_insn_o, INSN_NOP);
  endtask

  initial begin
    checks = 0; failures = 0; finished = 0;
    rr_insn_i = INSN_NOP; rr_pred_i = 1'b0; rr_pc_i = '0;
    @(negedge clk);
    t_reset();
    t_carry();
    t_mispredict_taken();
    t_mispredict_not_taken();
    t_correct();
    t_nonbranch();
    t_priority();
    t_stall_pulse();
    t_stall_squash();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule